// File: doc/BRIEF.md
# Cache Test Register Interface

This block is a debug access port into a 4-way set-associative cache of 128 sets with 16-byte lines. Software sees three 32-bit registers: a data register, a status register and a control register. Writing the control register starts an operation, chosen by its two lowest bits: a buffer access, a line write, a line read, or a flush of the whole cache. A line is staged one doubleword at a time in a 128-bit fill buffer before a line write. A line read delivers its data into a 128-bit read buffer, which is read back one doubleword at a time.

The cache arrays for tag, coherency state, pseudo-LRU and data are kept as plain internal storage. The operating mode is fixed during reset. In write-back mode every way carries a 2-bit coherency state, and an extension bit in the control register switches the status register from its tag view to a view of the per-way states. In write-through mode only a valid bit is kept, and neither the extension bit nor the state field can be written. Every operation completes on the clock edge that accepts the control write, so a status readback in the next cycle already shows the result.

Top module: `cache_test_regs`

## Requirements
- R1: Register select `reg_addr` is 0 for data, 1 for status and 2 for control; address 3 reads as zero. A control write carries an operation code in bits 1:0: 00 buffer access, 01 line write, 10 line read, 11 flush. The result is visible on `reg_rdata` in the cycle after the write.
- R2: Control bits 10:4 select the set. Control bits 3:2 select the way for a line write or line read. For a buffer access the same bits select doubleword n, which occupies bits 32n+31:32n of the line.
- R3: A data-register write fills the fill-buffer doubleword selected by control bits 3:2, but only while the stored operation code is 00; otherwise it is ignored. A data-register read returns the read-buffer doubleword selected by control bits 3:2.
- R4: A line read loads the status register as follows: tag in bits 31:11, the valid flag of the read way in bit 10, the set's LRU bits in 9:7, and the set's valid flags in 6:3 (way w at bit 3+w), with bits 2:0 zero. It also copies the line into the read buffer.
- R5: In write-back mode a line write stores the state given by control bits 18:17 (00 invalid, 01 shared, 10 exclusive, 11 modified) and ignores status bit 10. In write-through mode a line write takes validity from status bit 10 and ignores bits 18:17.
- R6: A status-register write changes only the tag and bit 10. The LRU bits and the per-way valid flags are left untouched.
- R7: In write-back mode a way reads as valid exactly when its state is shared, exclusive or modified.
- R8: With control bit 19 set in write-back mode, the status register reads as follows: bits 30:29 hold the state of the way named by control bits 18:17, bits 27:20 hold the states of all four ways (way w at bits 21+2w:20+2w), bits 31, 28 and 19:11 read zero, and bits 10:0 are unchanged. While this view is active, tag writes are ignored.
- R9: A flush clears the state and the LRU bits of every set, whatever the set and way fields say. Tags and line data are kept.
- R10: The mode is taken from `wb_mode_pin` while `rst_n` is low (high selects write-back) and is held after reset. In write-through mode control bits 19 and 18:17 always read zero. After reset, the control, status and both buffers read zero.
- R11: The LRU bits are {pair of ways 2/3, pair of ways 0/1, root} at status bits 9:7 and are 000 after reset. A line write to way w sets the root to the inverse of w[1] and the bit of w's pair to the inverse of w[0]. The bit of the other pair is unchanged.
- R12: Control readback shows bit 19 as the extension bit, 18:17 as the state field, 10:4 as the set, 3:2 as the way and 1:0 as the last operation code. All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the mode pin is sampled while it is low |
| wb_mode_pin | input | 1 | Mode select: 1 write-back, 0 write-through |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |

## Verification
The assertions assume that software writes at most one register per cycle, and that the mode pin moves only while reset is held. Under those assumptions, one control write never launches more than one operation, and the mode latch never changes in service. The stimulus issues a single write at a time, with idle cycles between writes. It changes the mode pin only inside the reset task, and it line-reads only sets whose tags it wrote first, so every readback has a defined expected value.

// File: rtl/cti_pkg.sv
package cti_pkg;
  localparam int unsigned WAYS  = 4;
  localparam int unsigned WORDS = 4;
  localparam int unsigned DW    = 32;
  localparam int unsigned LINE_W = WORDS * DW;

  typedef enum logic [1:0] {
    OP_BUF   = 2'b00,
    OP_LWR   = 2'b01,
    OP_LRD   = 2'b10,
    OP_FLUSH = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_INV = 2'b00,
    ST_SHR = 2'b01,
    ST_EXC = 2'b10,
    ST_MOD = 2'b11
  } coh_e;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;

  // tree bits: [2] pair 2/3, [1] pair 0/1, [0] root
  function automatic logic [2:0] plru_next(input logic [2:0] cur, input logic [1:0] way);
    logic [2:0] r;
    r    = cur;
    r[0] = ~way[1];
    if (way[1]) r[2] = ~way[0];
    else        r[1] = ~way[0];
    return r;
  endfunction

  function automatic logic coh_valid(input logic [1:0] st);
    return st != ST_INV;
  endfunction

  function automatic logic [1:0] wt_state(input logic vld);
    return vld ? ST_EXC : ST_INV;
  endfunction
endpackage

// File: rtl/cti_decode.sv
module cti_decode
  import cti_pkg::*;
#(
  parameter int unsigned IDX_LO = 4,
  parameter int unsigned IDX_W  = 7
) (
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [19:0]       ctl_word,
  input  logic              wb_mode,
  input  logic [1:0]        cur_op,
  output logic              ctrl_we,
  output logic              stat_we,
  output logic              fill_we,
  output logic              lwr_fire,
  output logic              lrd_fire,
  output logic              flush_fire,
  output logic              n_ext,
  output logic [1:0]        n_sst,
  output logic [IDX_W-1:0]  n_idx,
  output logic [1:0]        n_way,
  output logic [1:0]        n_op
);
  logic unused_bits;
  assign unused_bits = ^ctl_word[16:IDX_LO+IDX_W];

  assign ctrl_we    = reg_we && (reg_addr == A_CTRL);
  assign stat_we    = reg_we && (reg_addr == A_STAT);
  assign fill_we    = reg_we && (reg_addr == A_DATA) && (cur_op == OP_BUF);

  assign n_op       = ctl_word[1:0];
  assign n_way      = ctl_word[3:2];
  assign n_idx      = ctl_word[IDX_LO +: IDX_W];
  assign n_ext      = wb_mode & ctl_word[19];
  assign n_sst      = wb_mode ? ctl_word[18:17] : 2'b00;

  assign lwr_fire   = ctrl_we && (n_op == OP_LWR);
  assign lrd_fire   = ctrl_we && (n_op == OP_LRD);
  assign flush_fire = ctrl_we && (n_op == OP_FLUSH);
endmodule

// File: rtl/cti_store.sv
module cti_store
  import cti_pkg::*;
#(
  parameter int unsigned SET_N = 128,
  parameter int unsigned TAG_W = 21,
  localparam int unsigned IDX_W = $clog2(SET_N),
  localparam int unsigned LINES = SET_N * WAYS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wb_mode,
  input  logic                  lwr_fire,
  input  logic                  flush_fire,
  input  logic [IDX_W-1:0]      idx,
  input  logic [1:0]            way,
  input  logic [1:0]            sst,
  input  logic                  wr_valid,
  input  logic [TAG_W-1:0]      wr_tag,
  input  logic [LINE_W-1:0]     wr_line,
  output logic [TAG_W-1:0]      rd_tag,
  output logic [LINE_W-1:0]     rd_line,
  output logic [2*WAYS-1:0]     rd_st,
  output logic [2:0]            rd_lru,
  output logic                  any_valid
);
  logic [TAG_W-1:0]  tag_a  [LINES];
  logic [LINE_W-1:0] data_a [LINES];
  logic [1:0]        st_a   [LINES];
  logic [2:0]        lru_a  [SET_N];

  logic [IDX_W+1:0] lin;
  assign lin = {idx, way};

  always_ff @(posedge clk) begin
    if (lwr_fire) begin
      tag_a[lin]  <= wr_tag;
      data_a[lin] <= wr_line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_a[i] <= ST_INV;
      for (int s = 0; s < SET_N; s++) lru_a[s] <= 3'b000;
    end else if (flush_fire) begin
      for (int i = 0; i < LINES; i++) st_a[i] <= ST_INV;
      for (int s = 0; s < SET_N; s++) lru_a[s] <= 3'b000;
    end else if (lwr_fire) begin
      st_a[lin]  <= wb_mode ? sst : wt_state(wr_valid);
      lru_a[idx] <= plru_next(lru_a[idx], way);
    end
  end

  assign rd_tag  = tag_a[lin];
  assign rd_line = data_a[lin];
  assign rd_lru  = lru_a[idx];

  for (genvar w = 0; w < WAYS; w++) begin : g_gather
    assign rd_st[2*w +: 2] = st_a[{idx, 2'(w)}];
  end

  always_comb begin
    any_valid = 1'b0;
    for (int i = 0; i < LINES; i++) any_valid = any_valid | coh_valid(st_a[i]);
  end
endmodule

// File: rtl/cti_view.sv
module cti_view
  import cti_pkg::*;
#(
  parameter int unsigned IDX_LO = 4,
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned TAG_LO = 11,
  localparam int unsigned TAG_W = DW - TAG_LO
) (
  input  logic [1:0]        reg_addr,
  input  logic              ext_view,
  input  logic              c_ext,
  input  logic [1:0]        c_sst,
  input  logic [IDX_W-1:0]  c_idx,
  input  logic [1:0]        c_way,
  input  logic [1:0]        c_op,
  input  logic [TAG_W-1:0]  s_tag,
  input  logic              s_valid,
  input  logic [2:0]        s_lru,
  input  logic [WAYS-1:0]   s_vld,
  input  logic [2*WAYS-1:0] s_st,
  input  logic [LINE_W-1:0] rbuf,
  output logic [DW-1:0]     reg_rdata
);
  function automatic logic [DW-1:0] pack_status();
    logic [DW-1:0] v;
    v       = '0;
    v[10]   = s_valid;
    v[9:7]  = s_lru;
    v[6:3]  = s_vld;
    if (ext_view) begin
      v[30:29] = s_st[2*c_sst +: 2];
      v[27:20] = s_st;
    end else begin
      v[DW-1:TAG_LO] = s_tag;
    end
    return v;
  endfunction

  function automatic logic [DW-1:0] pack_ctrl();
    logic [DW-1:0] v;
    v                  = '0;
    v[19]              = c_ext;
    v[18:17]           = c_sst;
    v[IDX_LO +: IDX_W] = c_idx;
    v[3:2]             = c_way;
    v[1:0]             = c_op;
    return v;
  endfunction

  always_comb begin
    unique case (reg_addr)
      A_DATA:  reg_rdata = rbuf[DW*c_way +: DW];
      A_STAT:  reg_rdata = pack_status();
      A_CTRL:  reg_rdata = pack_ctrl();
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cache_test_regs.sv
module cache_test_regs
  import cti_pkg::*;
#(
  parameter int unsigned SET_N  = 128,
  parameter int unsigned IDX_LO = 4,
  localparam int unsigned IDX_W  = $clog2(SET_N),
  localparam int unsigned TAG_LO = IDX_LO + IDX_W,
  localparam int unsigned TAG_W  = DW - TAG_LO
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wb_mode_pin,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata
);
  logic              wb_q;
  logic              c_ext;
  logic [1:0]        c_sst, c_way, c_op;
  logic [IDX_W-1:0]  c_idx;
  logic [TAG_W-1:0]  s_tag;
  logic              s_valid;
  logic [2:0]        s_lru;
  logic [WAYS-1:0]   s_vld;
  logic [2*WAYS-1:0] s_st;
  logic [LINE_W-1:0] fill_line, rbuf_line;

  logic              ctrl_we, stat_we, fill_we, lwr_fire, lrd_fire, flush_fire;
  logic              n_ext;
  logic [1:0]        n_sst, n_way, n_op;
  logic [IDX_W-1:0]  n_idx;
  logic [TAG_W-1:0]  rd_tag;
  logic [LINE_W-1:0] rd_line;
  logic [2*WAYS-1:0] rd_st;
  logic [2:0]        rd_lru;
  logic [WAYS-1:0]   rd_vld;
  logic              any_valid;
  logic              ext_view;

  assign ext_view = wb_q & c_ext;

  cti_decode #(.IDX_LO(IDX_LO), .IDX_W(IDX_W)) u_dec (
    .reg_we(reg_we), .reg_addr(reg_addr), .ctl_word(reg_wdata[19:0]),
    .wb_mode(wb_q), .cur_op(c_op),
    .ctrl_we(ctrl_we), .stat_we(stat_we), .fill_we(fill_we),
    .lwr_fire(lwr_fire), .lrd_fire(lrd_fire), .flush_fire(flush_fire),
    .n_ext(n_ext), .n_sst(n_sst), .n_idx(n_idx), .n_way(n_way), .n_op(n_op)
  );

  cti_store #(.SET_N(SET_N), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_q),
    .lwr_fire(lwr_fire), .flush_fire(flush_fire),
    .idx(n_idx), .way(n_way), .sst(n_sst),
    .wr_valid(s_valid), .wr_tag(s_tag), .wr_line(fill_line),
    .rd_tag(rd_tag), .rd_line(rd_line), .rd_st(rd_st), .rd_lru(rd_lru),
    .any_valid(any_valid)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_vld
    assign rd_vld[w] = coh_valid(rd_st[2*w +: 2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_q      <= wb_mode_pin;
      c_ext     <= 1'b0;
      c_sst     <= '0;
      c_idx     <= '0;
      c_way     <= '0;
      c_op      <= '0;
      s_tag     <= '0;
      s_valid   <= 1'b0;
      s_lru     <= '0;
      s_vld     <= '0;
      s_st      <= '0;
      fill_line <= '0;
      rbuf_line <= '0;
    end else begin
      if (ctrl_we) begin
        c_ext <= n_ext;
        c_sst <= n_sst;
        c_idx <= n_idx;
        c_way <= n_way;
        c_op  <= n_op;
      end
      if (fill_we) fill_line[DW*c_way +: DW] <= reg_wdata;
      if (stat_we) begin
        s_valid <= reg_wdata[10];
        if (!ext_view) s_tag <= reg_wdata[DW-1:TAG_LO];
      end
      if (lrd_fire) begin
        s_tag     <= rd_tag;
        s_valid   <= rd_vld[n_way];
        s_lru     <= rd_lru;
        s_vld     <= rd_vld;
        s_st      <= rd_st;
        rbuf_line <= rd_line;
      end
    end
  end

  cti_view #(.IDX_LO(IDX_LO), .IDX_W(IDX_W), .TAG_LO(TAG_LO)) u_view (
    .reg_addr(reg_addr), .ext_view(ext_view),
    .c_ext(c_ext), .c_sst(c_sst), .c_idx(c_idx), .c_way(c_way), .c_op(c_op),
    .s_tag(s_tag), .s_valid(s_valid), .s_lru(s_lru), .s_vld(s_vld), .s_st(s_st),
    .rbuf(rbuf_line), .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/cti_checker.sv
module cti_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wb_q,
  input logic       c_ext,
  input logic [1:0] c_sst,
  input logic [1:0] n_sst,
  input logic       stat_we,
  input logic       fill_we,
  input logic       lwr_fire,
  input logic       lrd_fire,
  input logic       flush_fire,
  input logic [2:0] s_lru,
  input logic [3:0] s_vld,
  input logic       any_valid
);
  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lwr_fire, lrd_fire, flush_fire, fill_we})); // R1

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush_fire |=> !any_valid); // R9

  AST_WB_STATE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (lwr_fire && wb_q && n_sst != 2'b00) |=> any_valid); // R7

  AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && !lrd_fire) |=> ($stable(s_lru) && $stable(s_vld))); // R6

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(wb_q)); // R10

  AST_WT_NO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_q |-> (!c_ext && c_sst == 2'b00)); // R10
endmodule

bind cache_test_regs cti_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wb_q(wb_q), .c_ext(c_ext), .c_sst(c_sst),
  .n_sst(n_sst), .stat_we(stat_we), .fill_we(fill_we), .lwr_fire(lwr_fire),
  .lrd_fire(lrd_fire), .flush_fire(flush_fire), .s_lru(s_lru), .s_vld(s_vld),
  .any_valid(any_valid)
);

// File: tb/cache_test_regs_tb.sv
module cache_test_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wb_mode_pin = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cache_test_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wb_mode_pin(wb_mode_pin), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // reference model
  logic [20:0] m_tag  [128][4];
  logic [1:0]  m_st   [128][4];
  logic [2:0]  m_lru  [128];
  logic [31:0] m_data [128][4][4];
  logic [31:0] m_fill [4];
  logic [31:0] m_rbuf [4];
  logic        wb;
  logic        c_ext;
  logic [1:0]  c_sst, c_way, c_op;
  logic [6:0]  c_idx;
  logic [20:0] s_tag;
  logic        s_valid;
  logic [2:0]  s_lru;
  logic [3:0]  s_vld;
  logic [7:0]  s_st;

  function automatic logic [2:0] lru_after(input logic [2:0] l, input logic [1:0] w);
    case (w)
      2'd0: return {l[2], 1'b1, 1'b1};
      2'd1: return {l[2], 1'b0, 1'b1};
      2'd2: return {1'b1, l[1], 1'b0};
      default: return {1'b0, l[1], 1'b0};
    endcase
  endfunction

  function automatic logic [31:0] exp_status();
    if (wb && c_ext)
      return {1'b0, s_st[2*c_sst +: 2], 1'b0, s_st, 9'b0, s_valid, s_lru, s_vld, 3'b0};
    return {s_tag, s_valid, s_lru, s_vld, 3'b0};
  endfunction

  function automatic logic [31:0] exp_ctrl();
    return {12'b0, c_ext, c_sst, 6'b0, c_idx, c_way, c_op};
  endfunction

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic chk(input logic [1:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr %0d actual %h expected %h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic set_ctrl(input logic ext, input logic [1:0] sst, input logic [6:0] idx,
                          input logic [1:0] way, input logic [1:0] op);
    wreg(2'd2, {12'b0, ext, sst, 6'b0, idx, way, op});
    c_ext = wb & ext;
    c_sst = wb ? sst : 2'b00;
    c_idx = idx; c_way = way; c_op = op;
    case (op)
      2'b01: begin
        m_tag[idx][way] = s_tag;
        for (int k = 0; k < 4; k++) m_data[idx][way][k] = m_fill[k];
        m_st[idx][way] = wb ? sst : (s_valid ? 2'b10 : 2'b00);
        m_lru[idx] = lru_after(m_lru[idx], way);
      end
      2'b10: begin
        s_tag = m_tag[idx][way];
        s_valid = (m_st[idx][way] != 2'b00);
        s_lru = m_lru[idx];
        for (int w = 0; w < 4; w++) begin
          s_vld[w] = (m_st[idx][w] != 2'b00);
          s_st[2*w +: 2] = m_st[idx][w];
        end
        for (int k = 0; k < 4; k++) m_rbuf[k] = m_data[idx][way][k];
      end
      2'b11: begin
        for (int s = 0; s < 128; s++) begin
          m_lru[s] = 3'b000;
          for (int w = 0; w < 4; w++) m_st[s][w] = 2'b00;
        end
      end
      default: ;
    endcase
  endtask

  task automatic write_data(input logic [31:0] d);
    wreg(2'd0, d);
    if (c_op == 2'b00) m_fill[c_way] = d;
  endtask

  task automatic write_status(input logic [31:0] d);
    wreg(2'd1, d);
    s_valid = d[10];
    if (!(wb && c_ext)) s_tag = d[31:11];
  endtask

  task automatic do_reset(input logic mode);
    wb_mode_pin = mode;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wb = mode;
    c_ext = 0; c_sst = 0; c_idx = 0; c_way = 0; c_op = 0;
    s_tag = 0; s_valid = 0; s_lru = 0; s_vld = 0; s_st = 0;
    for (int k = 0; k < 4; k++) begin m_fill[k] = 0; m_rbuf[k] = 0; end
    for (int s = 0; s < 128; s++) begin
      m_lru[s] = 0;
      for (int w = 0; w < 4; w++) m_st[s][w] = 0;
    end
  endtask

  task automatic line_write(input logic [6:0] idx, input logic [1:0] way,
                            input logic [20:0] tag, input logic vld,
                            input logic [1:0] sst, input logic [31:0] base);
    for (int k = 0; k < 4; k++) begin
      set_ctrl(1'b0, 2'b00, idx, 2'(k), 2'b00);
      write_data(base + 32'(k));
    end
    write_status({tag, vld, 10'b0});
    set_ctrl(1'b0, sst, idx, way, 2'b01);
  endtask

  task automatic check_line(input string req);
    for (int k = 0; k < 4; k++) begin
      set_ctrl(1'b0, 2'b00, c_idx, 2'(k), 2'b00);
      chk(2'd0, m_rbuf[k], req);
    end
  endtask

  function automatic logic [6:0] pick_idx();
    logic [31:0] r;
    r = $urandom;
    return r[0] ? {4'b0, r[3:1]} : (7'd120 + {4'b0, r[3:1]});
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    do_reset(1'b1);
    chk(2'd2, 32'h0, "R10 control after reset");
    chk(2'd1, 32'h0, "R10 status after reset");
    chk(2'd0, 32'h0, "R10 read buffer after reset");
    chk(2'd3, 32'h0, "R1 unused address");

    // populate sets 0..7 and 120..127 in write-back mode
    for (int s = 0; s < 16; s++) begin
      for (int w = 0; w < 4; w++) begin
        line_write(s < 8 ? 7'(s) : 7'(112 + s), 2'(w), 21'($urandom),
                   1'b1, 2'(1 + ($urandom % 3)), $urandom);
      end
    end

    // R4 / R2: line read of set 3 way 2
    set_ctrl(1'b0, 2'b00, 7'd3, 2'd2, 2'b10);
    chk(2'd1, exp_status(), "R4 status after line read");
    chk(2'd2, exp_ctrl(), "R12 control readback");
    check_line("R2 R3 read buffer words");

    // R8: extended view, state field picks each way
    for (int w = 0; w < 4; w++) begin
      set_ctrl(1'b1, 2'(w), 7'd3, 2'd0, 2'b00);
      chk(2'd1, exp_status(), "R8 state view");
    end
    write_status(32'h0);
    chk(2'd1, exp_status(), "R8 tag write ignored in state view");
    set_ctrl(1'b0, 2'b00, 7'd3, 2'd0, 2'b00);
    chk(2'd1, exp_status(), "R8 tag view restored");

    // R6: read-only fields untouched by status write
    write_status(32'hFFFF_FFFF);
    chk(2'd1, exp_status(), "R6 LRU and valid flags read-only");
    write_status(32'h0000_0000);
    chk(2'd1, exp_status(), "R6 LRU and valid flags read-only");

    // R3: data write ignored while op is not a buffer access
    set_ctrl(1'b0, 2'b00, 7'd1, 2'd0, 2'b10);
    write_data(32'hDEAD_BEEF);
    set_ctrl(1'b0, 2'b00, 7'd2, 2'd1, 2'b01);
    set_ctrl(1'b0, 2'b00, 7'd2, 2'd1, 2'b10);
    check_line("R3 fill ignored outside buffer op");

    // R5 / R7: write-back state comes from set-state field
    line_write(7'd4, 2'd1, 21'h1ABCD, 1'b0, 2'b11, 32'h100);
    set_ctrl(1'b0, 2'b00, 7'd4, 2'd1, 2'b10);
    chk(2'd1, exp_status(), "R5 R7 modified reads valid, status valid ignored");
    line_write(7'd4, 2'd1, 21'h1ABCD, 1'b1, 2'b00, 32'h200);
    set_ctrl(1'b0, 2'b00, 7'd4, 2'd1, 2'b10);
    chk(2'd1, exp_status(), "R5 R7 invalid state overrides status valid");
    line_write(7'd4, 2'd2, 21'h00077, 1'b0, 2'b01, 32'h300);
    set_ctrl(1'b1, 2'b10, 7'd4, 2'd2, 2'b10);
    chk(2'd1, exp_status(), "R7 R8 shared state view");

    // R11: LRU tree sequence on set 5
    for (int i = 0; i < 6; i++) begin
      logic [1:0] w;
      w = 2'((i * 3 + 1) % 4);
      line_write(7'd5, w, 21'(i), 1'b1, 2'b10, 32'(i * 16));
      set_ctrl(1'b0, 2'b00, 7'd5, w, 2'b10);
      chk(2'd1, exp_status(), "R11 pseudo-LRU after write");
    end

    // R9: flush with arbitrary other fields
    set_ctrl(1'b1, 2'b11, 7'd77, 2'd3, 2'b11);
    chk(2'd2, exp_ctrl(), "R12 control after flush");
    set_ctrl(1'b0, 2'b00, 7'd6, 2'd3, 2'b10);
    chk(2'd1, exp_status(), "R9 flush cleared state and LRU, tag kept");
    check_line("R9 data kept across flush");

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      int r;
      r = $urandom % 7;
      case (r)
        0: begin set_ctrl(1'b0, 2'b00, pick_idx(), 2'($urandom), 2'b00); write_data($urandom); end
        1: write_status($urandom);
        2: set_ctrl(1'($urandom), 2'($urandom), pick_idx(), 2'($urandom), 2'b01);
        3: set_ctrl(1'($urandom), 2'($urandom), pick_idx(), 2'($urandom), 2'b10);
        4: set_ctrl(1'($urandom), 2'($urandom), pick_idx(), 2'($urandom), 2'b00);
        5: if ($urandom % 8 == 0) set_ctrl(1'($urandom), 2'($urandom), 7'($urandom), 2'($urandom), 2'b11);
        default: write_data($urandom);
      endcase
      chk(2'd1, exp_status(), "R4 R8 random status");
      chk(2'd2, exp_ctrl(), "R12 random control");
      chk(2'd0, m_rbuf[c_way], "R3 random read buffer");
    end

    // write-through mode
    do_reset(1'b0);
    chk(2'd2, 32'h0, "R10 control after write-through reset");
    set_ctrl(1'b1, 2'b11, 7'd7, 2'd2, 2'b00);
    chk(2'd2, exp_ctrl(), "R10 extension and state masked in write-through");
    line_write(7'd7, 2'd2, 21'h0F0F0, 1'b1, 2'b00, 32'h400);
    set_ctrl(1'b1, 2'b00, 7'd7, 2'd2, 2'b10);
    chk(2'd1, exp_status(), "R5 write-through valid from status bit");
    line_write(7'd7, 2'd3, 21'h0A0A0, 1'b0, 2'b11, 32'h500);
    set_ctrl(1'b0, 2'b00, 7'd7, 2'd3, 2'b10);
    chk(2'd1, exp_status(), "R5 write-through state field ignored");
    check_line("R2 write-through line data");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule